// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block turns an asynchronous NRZ serial line back into parallel characters. The line idles high. A character starts with a low start bit, then carries eight or nine data bits, least significant first, and ends with a high stop bit. The receiver takes one sample per pulse of an oversampling tick, at sixteen ticks per bit. It finds the falling edge that opens a frame. For each bit it takes three samples near the middle and lets the majority decide the value. If the three samples do not all agree, it records that the line was noisy.

Each completed character is copied into a holding register in one step. The shift path is then free to take in the next character while the previous one waits to be read. The holding register raises a ready flag. It also carries three flags for the character: noise, framing error and overrun. A read-acknowledge pulse marks the character as consumed. The block does not generate the tick and does not produce interrupts.

Top module: `rxo_receiver`

## Requirements
- R1: After reset, `rx_data`, `data_rdy`, `overrun`, `noise_err` and `frame_err` are all 0.
- R2: A frame starts only when a tick samples the line low and the previous tick sampled it high. That first low sample is tick 0 of the start bit. The samples at ticks 7, 8 and 9 are voted. If the majority is 1, the start is dropped and no character is delivered.
- R3: In 8-bit mode (`nine_bit`=0 when the start is detected), eight data bits are taken LSB first into `rx_data[7:0]`, and `rx_data[8]` reads 0.
- R4: In 9-bit mode (`nine_bit`=1 when the start is detected), nine data bits are taken LSB first into `rx_data[8:0]`.
- R5: The value of each bit is the majority of its samples at ticks 7, 8 and 9, counting from the bit's tick 0. A single sample that disagrees does not change the value.
- R6: `noise_err` is set for a character when, in any of its start, data or stop bits, the three voted samples do not all agree.
- R7: `frame_err` is set when the stop bit votes 0. A character of all-zero data with `frame_err` set is a break.
- R8: If a character completes while `data_rdy` is 1 and `rd_ack` is 0, `overrun` is set. The new character is discarded, and `rx_data` and the other flags keep their values.
- R9: A one-cycle `rd_ack` clears `data_rdy`, `noise_err`, `frame_err` and `overrun` on the next clock edge. If a character completes in the same cycle, it is loaded and no overrun is recorded.
- R10: While `rx_en` is 0, the receiver abandons any frame in progress and detects no start. After `rx_en` returns to 1, the line must be sampled high before a start can be detected.
- R11: A character can be shifted in while the previous one waits. If `rd_ack` arrives before the new character completes, the new character is delivered with no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxd | input | 1 | Asynchronous serial line, idle high |
| tick | input | 1 | One-clock strobe, sixteen per bit time |
| rx_en | input | 1 | Receive enable |
| nine_bit | input | 1 | Word length select: 1 for nine data bits, 0 for eight |
| rd_ack | input | 1 | One-cycle pulse marking the held character as consumed |
| rx_data | output | 9 | Held character |
| data_rdy | output | 1 | Holding register contains an unread character |
| overrun | output | 1 | A character was lost because the holding register was full |
| noise_err | output | 1 | Held character had a bit whose samples disagreed |
| frame_err | output | 1 | Held character had a stop bit that voted 0 |

## Verification
The assertions assume `rd_ack` is a single-cycle pulse. They also assume a character cannot complete in the cycle right after an acknowledge, which holds because a frame lasts many ticks. The stimulus drives the line only between ticks, and changes it at least three clocks before the next tick, so every synchronized sample is settled. It sends only whole sixteen-tick bits. Noise is added by flipping one or two of the three centre samples of a chosen bit. A double flip is never applied to the start bit or the stop bit in the random part, so the reference model is never asked to predict a rejected frame by accident.

// File: rtl/rxo_pkg.sv
// Package: shared receiver state type.
// Assumes: none.
package rxo_pkg;
    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } rx_state_t;
endpackage

// File: rtl/rxo_sync.sv
// Module: brings the asynchronous serial line into the clock domain.
// Assumes: the line idles high, so every stage resets to 1.
module rxo_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Shift the line through the synchronizer stages.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/rxo_voter.sv
// Module: keeps the two earlier centre samples of a bit and votes them
//         with the current sample.
// Assumes: decide is asserted together with the third capture.
module rxo_voter (
    input  logic clk,
    input  logic rst_n,
    input  logic capture,
    input  logic line,
    output logic vote,
    output logic clean
);
    logic [1:0] held;

    // Store the centre samples as they are taken.
    always_ff @(posedge clk) begin
        if (!rst_n)       held <= 2'b11;
        else if (capture) held <= {held[0], line};
    end

    // Majority of three, and agreement of all three.
    always_comb begin
        vote  = (held[1] & held[0]) | (held[1] & line) | (held[0] & line);
        clean = (held[1] == held[0]) && (held[0] == line);
    end
endmodule

// File: rtl/rxo_framer.sv
// Module: hunts for a start edge, counts ticks within each bit, and steers
//         the voter. Assembles the character and reports its completion.
// Assumes: tick is a one-clock strobe; line is already synchronized.
module rxo_framer
    import rxo_pkg::*;
#(
    parameter int OSR    = 16,
    parameter int MID    = 8,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line,
    input  logic              rx_en,
    input  logic              nine_bit,
    input  logic              vote,
    input  logic              clean,
    output logic              capture,
    output logic              done,
    output logic              busy,
    output logic [DATA_W-1:0] char_o,
    output logic              noise_o,
    output logic              frame_o
);
    localparam int CW = $clog2(OSR);
    localparam int BW = $clog2(DATA_W);
    localparam logic [CW-1:0] LAST_TICK = CW'(OSR - 1);
    localparam logic [CW-1:0] CAP_LO    = CW'(MID - 1);
    localparam logic [CW-1:0] CAP_HI    = CW'(MID + 1);

    rx_state_t         state;
    logic [CW-1:0]     cnt, cnt_nx;
    logic [BW-1:0]     bidx, last_bit;
    logic [DATA_W-1:0] shreg;
    logic              last_s, nine_q, noise_acc, decide;

    // Next tick index within the bit, and the capture and decision strobes.
    always_comb begin
        cnt_nx   = (cnt == LAST_TICK) ? '0 : cnt + 1'b1;
        capture  = tick && (state != ST_HUNT) && (cnt_nx >= CAP_LO) && (cnt_nx <= CAP_HI);
        decide   = tick && (state != ST_HUNT) && (cnt_nx == CAP_HI);
        last_bit = nine_q ? BW'(DATA_W - 1) : BW'(DATA_W - 2);
    end

    // Frame sequencing: hunt, start, data and stop bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_HUNT;
            cnt       <= '0;
            bidx      <= '0;
            shreg     <= '0;
            last_s    <= 1'b0;
            nine_q    <= 1'b0;
            noise_acc <= 1'b0;
            frame_o   <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!rx_en) begin
                state  <= ST_HUNT;
                last_s <= 1'b0;
            end else if (tick) begin
                last_s <= line;
                if (state == ST_HUNT) begin
                    if (last_s && !line) begin
                        state     <= ST_START;
                        cnt       <= '0;
                        bidx      <= '0;
                        nine_q    <= nine_bit;
                        noise_acc <= 1'b0;
                    end
                end else begin
                    cnt <= cnt_nx;
                    if (decide) noise_acc <= noise_acc | ~clean;
                    case (state)
                        ST_START: begin
                            if (decide && vote)   state <= ST_HUNT;
                            else if (cnt_nx == '0) state <= ST_DATA;
                        end
                        ST_DATA: begin
                            if (decide) shreg <= {vote, shreg[DATA_W-1:1]};
                            if (cnt_nx == '0) begin
                                if (bidx == last_bit) state <= ST_STOP;
                                else                  bidx  <= bidx + 1'b1;
                            end
                        end
                        ST_STOP: begin
                            if (decide) begin
                                frame_o <= ~vote;
                                done    <= 1'b1;
                                state   <= ST_HUNT;
                            end
                        end
                        default: state <= ST_HUNT;
                    endcase
                end
            end
        end
    end

    assign busy    = (state != ST_HUNT);
    assign noise_o = noise_acc;
    assign char_o  = nine_q ? shreg : {1'b0, shreg[DATA_W-1:1]};
endmodule

// File: rtl/rxo_holdreg.sv
// Module: parallel holding register with ready, noise, framing and
//         overrun flags.
// Assumes: done is a one-clock pulse; the acknowledge is handled first.
module rxo_holdreg #(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DATA_W-1:0] char_i,
    input  logic              noise_i,
    input  logic              frame_i,
    input  logic              rd_ack,
    output logic [DATA_W-1:0] data_o,
    output logic              rdy_o,
    output logic              ovr_o,
    output logic              noise_o,
    output logic              frame_o
);
    // Load completed characters, record overruns, clear on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o  <= '0;
            rdy_o   <= 1'b0;
            ovr_o   <= 1'b0;
            noise_o <= 1'b0;
            frame_o <= 1'b0;
        end else begin
            if (rd_ack) begin
                rdy_o   <= 1'b0;
                ovr_o   <= 1'b0;
                noise_o <= 1'b0;
                frame_o <= 1'b0;
            end
            if (done) begin
                if (rdy_o && !rd_ack) begin
                    ovr_o <= 1'b1;
                end else begin
                    data_o  <= char_i;
                    rdy_o   <= 1'b1;
                    noise_o <= noise_i;
                    frame_o <= frame_i;
                end
            end
        end
    end
endmodule

// File: rtl/rxo_receiver.sv
// Module: top of the oversampling receiver. Chains the synchronizer,
//         framer, voter and holding register.
// Assumes: tick runs at sixteen pulses per bit, one clock wide each.
module rxo_receiver #(
    parameter int OSR         = 16,
    parameter int MID         = 8,
    parameter int DATA_W      = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rxd,
    input  logic              tick,
    input  logic              rx_en,
    input  logic              nine_bit,
    input  logic              rd_ack,
    output logic [DATA_W-1:0] rx_data,
    output logic              data_rdy,
    output logic              overrun,
    output logic              noise_err,
    output logic              frame_err
);
    logic              line_s, capture, vote, clean, done, fr_busy, ch_noise, ch_frame;
    logic [DATA_W-1:0] ch_data;

    rxo_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rxd), .dout(line_s)
    );

    rxo_voter u_voter (
        .clk(clk), .rst_n(rst_n), .capture(capture), .line(line_s),
        .vote(vote), .clean(clean)
    );

    rxo_framer #(.OSR(OSR), .MID(MID), .DATA_W(DATA_W)) u_framer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .line(line_s), .rx_en(rx_en),
        .nine_bit(nine_bit), .vote(vote), .clean(clean), .capture(capture),
        .done(done), .busy(fr_busy), .char_o(ch_data), .noise_o(ch_noise),
        .frame_o(ch_frame)
    );

    rxo_holdreg #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .done(done), .char_i(ch_data),
        .noise_i(ch_noise), .frame_i(ch_frame), .rd_ack(rd_ack),
        .data_o(rx_data), .rdy_o(data_rdy), .ovr_o(overrun),
        .noise_o(noise_err), .frame_o(frame_err)
    );
endmodule

// File: rtl/rxo_receiver_chk.sv
// Module: property checker for the receiver, bound to the top module.
// Assumes: rd_ack is a single-cycle pulse.
module rxo_receiver_chk #(
    parameter int DATA_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_en,
    input logic              rd_ack,
    input logic              done,
    input logic              fr_busy,
    input logic [DATA_W-1:0] rx_data,
    input logic              data_rdy,
    input logic              overrun,
    input logic              noise_err,
    input logic              frame_err
);
    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> !data_rdy && !overrun && !noise_err && !frame_err); // R1
    AST_NOISE_NEEDS_RDY: assert property (@(posedge clk) disable iff (!rst_n) noise_err |-> data_rdy); // R6
    AST_FRAME_NEEDS_RDY: assert property (@(posedge clk) disable iff (!rst_n) frame_err |-> data_rdy); // R7
    AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n) data_rdy && !rd_ack && done |=> overrun && $stable(rx_data)); // R8
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) rd_ack |=> !overrun); // R9
    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !rx_en |=> !fr_busy); // R10
    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n) data_rdy && !rd_ack |=> data_rdy && $stable(rx_data)); // R11
endmodule

bind rxo_receiver rxo_receiver_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rd_ack(rd_ack), .done(done),
    .fr_busy(fr_busy), .rx_data(rx_data), .data_rdy(data_rdy),
    .overrun(overrun), .noise_err(noise_err), .frame_err(frame_err)
);

// File: tb/tb_rxo_receiver.sv
module tb_rxo_receiver;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       tick = 1'b0;
    logic       rx_en = 1'b1;
    logic       nine_bit = 1'b0;
    logic       rd_ack = 1'b0;
    logic [8:0] rx_data;
    logic       data_rdy, overrun, noise_err, frame_err;
    int         checks = 0;
    int         errors = 0;

    rxo_receiver dut (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .tick(tick), .rx_en(rx_en),
        .nine_bit(nine_bit), .rd_ack(rd_ack), .rx_data(rx_data),
        .data_rdy(data_rdy), .overrun(overrun), .noise_err(noise_err),
        .frame_err(frame_err)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // One line sample: set the line, let it settle, then pulse the tick.
    task automatic one_tick(input logic v);
        @(negedge clk) rxd = v;
        repeat (3) @(negedge clk);
        tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    // One bit of sixteen samples. gmode 1 flips sample 8; gmode 2 flips 7 and 8.
    task automatic send_bit(input logic v, input int gmode);
        for (int k = 0; k < 16; k++) begin
            logic s;
            s = v;
            if (gmode == 1 && k == 8) s = ~v;
            if (gmode == 2 && (k == 7 || k == 8)) s = ~v;
            one_tick(s);
        end
    endtask

    // Whole frame with idle lead-in and tail. gbit: 0 start, 1..n data, n+1 stop.
    task automatic send_frame(input logic [8:0] d, input logic nine, input logic stopv,
                              input int gbit, input int gmode);
        int n;
        n = nine ? 9 : 8;
        nine_bit = nine;
        one_tick(1'b1);
        one_tick(1'b1);
        send_bit(1'b0, (gbit == 0) ? gmode : 0);
        for (int i = 0; i < n; i++) send_bit(d[i], (gbit == i + 1) ? gmode : 0);
        send_bit(stopv, (gbit == n + 1) ? gmode : 0);
        one_tick(1'b1);
        one_tick(1'b1);
    endtask

    task automatic ack();
        @(negedge clk) rd_ack = 1'b1;
        @(negedge clk) rd_ack = 1'b0;
    endtask

    function automatic logic [8:0] exp_data(input logic [8:0] d, input logic nine,
                                            input int gbit, input int gmode);
        logic [8:0] r;
        r = nine ? d : {1'b0, d[7:0]};
        if (gmode == 2 && gbit >= 1 && gbit <= (nine ? 9 : 8)) r[gbit-1] = ~r[gbit-1];
        return r;
    endfunction

    task automatic expect_char(input string req, input logic [8:0] d, input logic nine,
                               input logic stopv, input int gbit, input int gmode);
        chk({req, " rdy"}, data_rdy, 1);
        chk({req, " data"}, rx_data, exp_data(d, nine, gbit, gmode));
        chk({req, " noise"}, noise_err, gmode != 0);
        chk({req, " frame"}, frame_err, !stopv);
        chk({req, " ovr"}, overrun, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=0 exp=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 data", rx_data, 0);
        chk("R1 flags", {data_rdy, overrun, noise_err, frame_err}, 0);

        // R3 clean 8-bit character
        send_frame(9'h0A5, 1'b0, 1'b1, -1, 0);
        expect_char("R3", 9'h0A5, 1'b0, 1'b1, -1, 0);
        ack();
        chk("R9 rdy cleared", data_rdy, 0);
        // R3 upper bit reads 0 in 8-bit mode
        send_frame(9'h1FF, 1'b0, 1'b1, -1, 0);
        expect_char("R3 upper", 9'h1FF, 1'b0, 1'b1, -1, 0);
        ack();
        // R4 nine-bit character
        send_frame(9'h1C3, 1'b1, 1'b1, -1, 0);
        expect_char("R4", 9'h1C3, 1'b1, 1'b1, -1, 0);
        ack();
        // R5 and R6: one stray sample keeps the value, flags noise
        send_frame(9'h03C, 1'b0, 1'b1, 4, 1);
        expect_char("R5 single", 9'h03C, 1'b0, 1'b1, 4, 1);
        ack();
        chk("R9 noise cleared", noise_err, 0);
        // R5 two of three samples flip the value
        send_frame(9'h055, 1'b0, 1'b1, 3, 2);
        expect_char("R5 double", 9'h055, 1'b0, 1'b1, 3, 2);
        ack();
        // R6 noise in the start bit and in the stop bit
        send_frame(9'h011, 1'b0, 1'b1, 0, 1);
        expect_char("R6 start", 9'h011, 1'b0, 1'b1, 0, 1);
        ack();
        send_frame(9'h122, 1'b1, 1'b1, 10, 1);
        expect_char("R6 stop", 9'h122, 1'b1, 1'b1, 10, 1);
        ack();
        // R7 framing error and break
        send_frame(9'h07E, 1'b0, 1'b0, -1, 0);
        expect_char("R7 frame", 9'h07E, 1'b0, 1'b0, -1, 0);
        ack();
        chk("R9 frame cleared", frame_err, 0);
        send_frame(9'h000, 1'b0, 1'b0, -1, 0);
        expect_char("R7 break", 9'h000, 1'b0, 1'b0, -1, 0);
        ack();
        // R2 short low pulse is rejected as a false start
        one_tick(1'b1);
        for (int k = 0; k < 6; k++) one_tick(1'b0);
        for (int k = 0; k < 30; k++) one_tick(1'b1);
        chk("R2 false start", data_rdy, 0);
        send_frame(9'h0C9, 1'b0, 1'b1, -1, 0);
        expect_char("R2 after reject", 9'h0C9, 1'b0, 1'b1, -1, 0);
        // R8 overrun keeps the held character
        send_frame(9'h033, 1'b0, 1'b1, -1, 0);
        chk("R8 ovr", overrun, 1);
        chk("R8 data kept", rx_data, 9'h0C9);
        chk("R8 rdy", data_rdy, 1);
        ack();
        chk("R9 ovr cleared", {data_rdy, overrun}, 0);
        // R11 acknowledge while the next character is shifting in
        send_frame(9'h081, 1'b0, 1'b1, -1, 0);
        fork
            send_frame(9'h042, 1'b0, 1'b1, -1, 0);
            begin repeat (300) @(negedge clk); ack(); end
        join
        expect_char("R11", 9'h042, 1'b0, 1'b1, -1, 0);
        ack();
        // R10 disabled receiver ignores a whole frame
        rx_en = 1'b0;
        send_frame(9'h0F0, 1'b0, 1'b1, -1, 0);
        chk("R10 disabled", data_rdy, 0);
        rx_en = 1'b1;
        // R10 frame abandoned midway, then a fresh frame arrives whole
        one_tick(1'b1);
        send_bit(1'b0, 0);
        send_bit(1'b1, 0);
        send_bit(1'b0, 0);
        @(negedge clk) rx_en = 1'b0;
        one_tick(1'b0);
        @(negedge clk) rx_en = 1'b1;
        send_frame(9'h0B7, 1'b0, 1'b1, -1, 0);
        expect_char("R10 resume", 9'h0B7, 1'b0, 1'b1, -1, 0);
        ack();

        // Constrained random characters
        for (int f = 0; f < 24; f++) begin
            logic [8:0] d;
            logic       nine, stopv;
            int         gmode, gbit, n;
            d     = 9'($urandom);
            nine  = 1'($urandom);
            n     = nine ? 9 : 8;
            stopv = ($urandom % 6) != 0;
            gmode = $urandom % 3;
            if (gmode == 2) gbit = 1 + ($urandom % n);
            else            gbit = $urandom % (n + 2);
            if (gmode == 0) gbit = -1;
            send_frame(d, nine, stopv, gbit, gmode);
            expect_char(nine ? "R4 rand" : "R3 rand", d, nine, stopv, gbit, gmode);
            ack();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule